// File: doc/BRIEF.md
# Projected-Iteration Control Circuit

This block is a control-token circuit for a program in which an outer statement advances at the slow rate set by the completions of an inner body. The outer statement is a wait on a `stopIn` condition. With `stopIn` held low it never finishes, so it acts as an endless loop. The inner body runs two one-cycle pauses side by side, and the second is followed by a pulse on `xOut`. When either side of that parallel pair finishes, the pair ends and its other side is cleared. Each pause and each wait keeps its state in one flip-flop. The outputs are combinational functions of those flip-flops and the current inputs.

`beginIn` starts the program. The outer wait takes one step at that moment and again in every cycle where the body finishes. If it does not finish in that step, a new body iteration starts in the same cycle. A body iteration starting in the cycle the previous one ends does not go through the body's main logic. It goes through a separate copy of the body's first-cycle logic, so the ending iteration cannot cancel the tokens of the new one. The next-state outputs of the two copies are ORed into the body flip-flops.

The parameter `DUP_FIRST` selects that copy. Setting it to 0 builds the flawed shared-logic variant, which is kept for comparison. `suspendIn` freezes the whole program. `resetIn` clears all control state at the next edge. `rst` is the synchronous global reset.

Top module: `temporal_projection`

## Requirements
- R1: After `rst`, and until `beginIn` is first high, `endOut` and `xOut` stay low.
- R2: With `DUP_FIRST`=1 and `stopIn`, `suspendIn` and `resetIn` low, `xOut` is low in the `beginIn` cycle. It is then high in every following cycle.
- R3: If `stopIn` is high in the `beginIn` cycle, `endOut` is high in that same cycle. The body is never started, so `xOut` stays low afterwards.
- R4: If `stopIn` is high in a later cycle where the body finishes, `endOut` is high in that cycle and `xOut` is still high there. From the next cycle both stay low until a new `beginIn`.
- R5: While `suspendIn` is high, `endOut` and `xOut` are low and all control state is held. In the first cycle after the suspension, the outputs continue as if the suspended cycles had not occurred.
- R6: `resetIn` high clears all control state at the next edge, even with `beginIn` or `suspendIn` high in the same cycle. From the next cycle `xOut` is low until a new `beginIn`.
- R7: With `DUP_FIRST`=0, `xOut` is high only in the second cycle of a run. It is never high in two consecutive cycles.
- R8: `stopIn` has no effect in a suspended cycle. A run with `stopIn` high only during suspension continues producing `xOut` once the suspension ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous global reset, active high |
| beginIn | input | 1 | Starts the program |
| suspendIn | input | 1 | Freezes all control state, forces outputs low |
| resetIn | input | 1 | Clears all control state at the next edge |
| stopIn | input | 1 | Condition that ends the outer wait |
| endOut | output | 1 | Program terminates in this cycle |
| xOut | output | 1 | Emission from the body's last step |

## Verification
The properties assume that `beginIn` and `suspendIn` are never high together. They also assume `beginIn` is raised only while the program is idle: after reset, after `resetIn`, or after `endOut`. The stimulus respects both. It issues a new `beginIn` only after a termination or a `resetIn`, and it keeps `beginIn` low during every suspended window. Within those limits the stimulus still applies `resetIn` together with `beginIn` and together with `suspendIn`, and raises `stopIn` inside suspended cycles.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int PAR_BRANCHES = 2;

  typedef struct packed {
    logic start;
    logic kill;
    logic hold;
  } bodyCtrl_t;

  typedef struct packed {
    logic done;
    logic emitX;
  } bodyStat_t;
endpackage

// File: rtl/tp_pause_cell.sv
module tp_pause_cell (
  input  logic beginIn,
  input  logic suspendIn,
  input  logic resetIn,
  input  logic prevIn,
  output logic endOut,
  output logic nextOut
);
  // token set on begin, released (end) one cycle later when not suspended
  assign endOut  = prevIn & ~suspendIn;
  assign nextOut = ~resetIn & (suspendIn ? prevIn : beginIn);
endmodule

// File: rtl/tp_await_cell.sv
module tp_await_cell (
  input  logic beginIn,
  input  logic suspendIn,
  input  logic resetIn,
  input  logic prevIn,
  input  logic condIn,
  output logic endOut,
  output logic nextOut
);
  logic live;
  assign live    = beginIn | (prevIn & ~suspendIn);
  assign endOut  = live & condIn;
  assign nextOut = ~resetIn & (suspendIn ? prevIn : (live & ~condIn));
endmodule

// File: rtl/tp_body.sv
module tp_body
  import tp_pkg::*;
#(
  parameter int DUP_FIRST = 1,
  parameter int LANES     = PAR_BRANCHES
) (
  input  logic      clk,
  input  logic      rst,
  input  bodyCtrl_t ctrl,
  output bodyStat_t stat
);
  localparam logic USE_COPY = (DUP_FIRST != 0);

  logic [LANES-1:0] qLat;
  logic [LANES-1:0] laneEnd;
  logic [LANES-1:0] mainNext;
  logic [LANES-1:0] firstNext;
  logic             parEnd;
  logic             mainBegin;
  logic             mainReset;

  assign mainBegin = USE_COPY ? 1'b0 : ctrl.start;
  assign parEnd    = |laneEnd;
  assign mainReset = ctrl.kill | parEnd;

  for (genvar i = 0; i < LANES; i++) begin : gLane
    tp_pause_cell uPause (
      .beginIn  (mainBegin),
      .suspendIn(ctrl.hold),
      .resetIn  (mainReset),
      .prevIn   (qLat[i]),
      .endOut   (laneEnd[i]),
      .nextOut  (mainNext[i])
    );
  end

  if (DUP_FIRST != 0) begin : gCopy
    // first-cycle copy: no suspend, no previous state, end discarded
    assign firstNext = {LANES{ctrl.start & ~ctrl.kill}};
  end else begin : gShared
    assign firstNext = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) qLat <= '0;
    else     qLat <= mainNext | firstNext;
  end

  assign stat.done  = parEnd;
  assign stat.emitX = laneEnd[LANES-1];
endmodule

// File: rtl/tp_ctrl.sv
module tp_ctrl
  import tp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      beginIn,
  input  logic      suspendIn,
  input  logic      resetIn,
  input  logic      stopIn,
  input  bodyStat_t stat,
  output bodyCtrl_t ctrl,
  output logic      endOut
);
  logic pLat;
  logic pNext;
  logic pSusp;
  logic pEnd;

  // outer statement only steps on begin or when the body finishes
  assign pSusp = suspendIn | (~beginIn & ~stat.done);

  tp_await_cell uAwait (
    .beginIn  (beginIn),
    .suspendIn(pSusp),
    .resetIn  (resetIn),
    .prevIn   (pLat),
    .condIn   (stopIn),
    .endOut   (pEnd),
    .nextOut  (pNext)
  );

  always_ff @(posedge clk) begin
    if (rst) pLat <= 1'b0;
    else     pLat <= pNext;
  end

  assign ctrl.start = (beginIn | stat.done) & ~pEnd;
  assign ctrl.kill  = resetIn | pEnd;
  assign ctrl.hold  = suspendIn;
  assign endOut     = pEnd;
endmodule

// File: rtl/temporal_projection.sv
module temporal_projection #(
  parameter int DUP_FIRST = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic beginIn,
  input  logic suspendIn,
  input  logic resetIn,
  input  logic stopIn,
  output logic endOut,
  output logic xOut
);
  tp_pkg::bodyCtrl_t bodyCtrl;
  tp_pkg::bodyStat_t bodyStat;

  tp_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .beginIn  (beginIn),
    .suspendIn(suspendIn),
    .resetIn  (resetIn),
    .stopIn   (stopIn),
    .stat     (bodyStat),
    .ctrl     (bodyCtrl),
    .endOut   (endOut)
  );

  tp_body #(.DUP_FIRST(DUP_FIRST)) uBody (
    .clk (clk),
    .rst (rst),
    .ctrl(bodyCtrl),
    .stat(bodyStat)
  );

  assign xOut = bodyStat.emitX;
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int DUP_FIRST = 1
) (
  input logic clk,
  input logic rst,
  input logic beginIn,
  input logic suspendIn,
  input logic resetIn,
  input logic stopIn,
  input logic endOut,
  input logic xOut
);
  AST_START_EMITS: assert property (@(posedge clk) disable iff (rst)
    beginIn && !stopIn && !resetIn |=> (xOut || suspendIn)); // R2
  AST_EARLY_END: assert property (@(posedge clk) disable iff (rst)
    beginIn && stopIn |-> endOut); // R3
  AST_EARLY_NO_BODY: assert property (@(posedge clk) disable iff (rst)
    beginIn && stopIn |=> !xOut); // R3
  AST_END_NEEDS_STOP: assert property (@(posedge clk) disable iff (rst)
    endOut |-> (stopIn && !suspendIn)); // R4
  AST_SUSPEND_QUIET: assert property (@(posedge clk) disable iff (rst)
    suspendIn |-> (!endOut && !xOut)); // R5
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    resetIn |=> !xOut); // R6

  if (DUP_FIRST != 0) begin : gDup
    AST_BODY_RESTARTS: assert property (@(posedge clk) disable iff (rst)
      xOut && !stopIn && !resetIn |=> (xOut || suspendIn)); // R2
  end else begin : gShared
    AST_SHARED_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
      xOut |=> !xOut); // R7
  end
endmodule

bind temporal_projection tp_checker #(.DUP_FIRST(DUP_FIRST)) uChk (
  .clk      (clk),
  .rst      (rst),
  .beginIn  (beginIn),
  .suspendIn(suspendIn),
  .resetIn  (resetIn),
  .stopIn   (stopIn),
  .endOut   (endOut),
  .xOut     (xOut)
);

// File: tb/sim_temporal_projection.sv
module sim_temporal_projection;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic beginIn = 1'b0, suspendIn = 1'b0, resetIn = 1'b0, stopIn = 1'b0;
  logic endOut0, xOut0, endOut1, xOut1;
  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit pOn[2];
  bit qOn[2];

  always #5 clk = ~clk;

  temporal_projection #(.DUP_FIRST(1)) u0 (
    .clk(clk), .rst(rst), .beginIn(beginIn), .suspendIn(suspendIn),
    .resetIn(resetIn), .stopIn(stopIn), .endOut(endOut0), .xOut(xOut0));

  temporal_projection #(.DUP_FIRST(0)) u1 (
    .clk(clk), .rst(rst), .beginIn(beginIn), .suspendIn(suspendIn),
    .resetIn(resetIn), .stopIn(stopIn), .endOut(endOut1), .xOut(xOut1));

  task automatic check(input logic act, input logic exp, input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // behavioural reference: outer-running flag and body-busy flag per instance
  task automatic step(input bit b, input bit s, input bit r, input bit st, input string tag);
    @(negedge clk);
    beginIn = b; suspendIn = s; resetIn = r; stopIn = st;
    #2;
    for (int k = 0; k < 2; k++) begin
      bit x, e, np, nq, fin, adv;
      if (s) begin
        x = 0; e = 0; np = pOn[k]; nq = qOn[k];
      end else begin
        fin = qOn[k];
        x   = fin;
        adv = b | (pOn[k] & fin);
        e   = adv & st;
        np  = (pOn[k] | b) & ~e;
        nq  = adv & ~e & ((k == 0) | ~fin);
      end
      if (r) begin np = 0; nq = 0; end
      check(k == 0 ? xOut0 : xOut1, x, {tag, (k == 0) ? " xOut u0" : " xOut u1"});
      check(k == 0 ? endOut0 : endOut1, e, {tag, (k == 0) ? " endOut u0" : " endOut u1"});
      pOn[k] = np; qOn[k] = nq;
    end
    cyc++;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(xOut0, 1'b0, "R1 xOut in reset");
    check(endOut0, 1'b0, "R1 endOut in reset");
    rst = 1'b0;
    for (int k = 0; k < 2; k++) begin pOn[k] = 0; qOn[k] = 0; end
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R1 idle");

    // R2 / R7: plain run, explicit per-cycle pattern on both variants
    for (int i = 0; i < 8; i++) begin
      step(i == 0, 0, 0, 0, "R2 run");
      check(xOut0, (i >= 1), "R2 xOut every cycle after start");
      check(xOut1, (i == 1), "R7 shared variant one-shot");
    end

    // R5: suspension window, then resume
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R5 suspended");
    step(0, 0, 0, 0, "R5 resume");
    check(xOut0, 1'b1, "R5 xOut right after suspension");

    // R8: stop high only while suspended has no effect
    for (int i = 0; i < 2; i++) step(0, 1, 0, 1, "R8 stop while suspended");
    step(0, 0, 0, 0, "R8 after suspension");
    check(endOut0, 1'b0, "R8 no end from suspended stop");
    check(xOut0, 1'b1, "R8 body still running");

    // R4: stop in a running cycle
    step(0, 0, 0, 1, "R4 stop");
    check(endOut0, 1'b1, "R4 end in stop cycle");
    check(xOut0, 1'b1, "R4 last emission in stop cycle");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R4 after end");

    // R3: stop on start
    step(1, 0, 0, 1, "R3 immediate");
    check(endOut0, 1'b1, "R3 end in begin cycle");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R3 body never starts");

    // R6: reset while running, with suspend, and with begin
    step(1, 0, 0, 0, "R6 start");
    step(0, 0, 0, 0, "R6 run");
    step(0, 0, 1, 0, "R6 reset");
    for (int i = 0; i < 2; i++) step(0, 0, 0, 0, "R6 after reset");
    step(1, 0, 0, 0, "R6 start2");
    step(0, 1, 1, 0, "R6 reset under suspend");
    for (int i = 0; i < 2; i++) step(0, 0, 0, 0, "R6 after reset under suspend");
    step(1, 0, 1, 0, "R6 reset with begin");
    for (int i = 0; i < 2; i++) step(0, 0, 0, 0, "R6 after reset with begin");
    check(xOut0, 1'b0, "R6 no emission after reset with begin");

    // mixed pattern: suspensions interleaved with a long run
    step(1, 0, 0, 0, "R2 mixed start");
    for (int i = 0; i < 20; i++) step(0, (i % 3) == 1, 0, 0, "R5 mixed");
    step(0, 0, 0, 1, "R4 mixed stop");
    step(0, 0, 0, 0, "R4 mixed idle");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule